// File: doc/BRIEF.md
# Set/Reset Output Port Controller

This block drives the eight general-purpose output pins of a dual serial controller. All pins are active-low. The host never writes a pin value directly. It writes a mask to a "set" address, and every pin whose mask bit is 1 goes low. It writes a mask to a "clear" address, and every pin whose mask bit is 1 goes high. Mask bits that are 0 leave their pins untouched, so independent pieces of software can share the port without a read-modify-write.

A function-select register can hand pin 0 and pins 5 to 7 to other sources. Pin 0 can show the channel-A request-to-send state, which is set and cleared through a command write. Pins 5, 6 and 7 can show inverted ready flags taken from the interrupt status. A pin handed to another source ignores set and clear writes to its latch bit. Two read addresses do nothing except fire one-cycle start and stop strobes toward an external counter/timer.

Top module: `gpo_setclr_port`

## Requirements
- R1: After a synchronous reset every pin is high, both strobes are low, every function-select bit is 0 and the request-to-send state is negated.
- R2: A write to address 0xE drives low, from the next cycle on, every latch-driven pin whose data bit is 1. Pins whose data bit is 0 keep their level.
- R3: A write to address 0xF drives high, from the next cycle on, every latch-driven pin whose data bit is 1. A low pin stays low through idle cycles, reads and writes to other addresses until a 0xF write with its bit at 1.
- R4: A write to address 0xD loads the function selects from data bits 0, 5, 6 and 7. With a select at 1, pin 5 is the inverse of the receiver-B-ready input, pin 6 is the inverse of transmitter-A-ready and pin 7 is the inverse of transmitter-B-ready, in the same cycle as the input changes. With a select at 0 the pin follows its latch bit.
- R5: While a pin's function select is 1, writes to 0xE and 0xF leave its latch bit unchanged. This is visible after the select returns to 0.
- R6: A write to address 0x2 with data[7:4] = 0x8 asserts the request-to-send state, and one with data[7:4] = 0x9 negates it. Any other upper nibble leaves it unchanged. With select bit 0 at 1, pin 0 is low exactly while that state is asserted.
- R7: A read of address 0xE raises the start strobe, and a read of 0xF raises the stop strobe, for the single cycle after the read. Reads of other addresses and all writes raise neither strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Register address |
| bus_wr | input | 1 | Write strobe, sampled on the rising edge |
| bus_rd | input | 1 | Read strobe, sampled on the rising edge |
| bus_wdata | input | N_PINS | Write data |
| rxb_ready | input | 1 | Receiver-B-ready status flag |
| txa_ready | input | 1 | Transmitter-A-ready status flag |
| txb_ready | input | 1 | Transmitter-B-ready status flag |
| port_n | output | N_PINS | Active-low output pins |
| ct_start | output | 1 | One-cycle counter/timer start strobe |
| ct_stop | output | 1 | One-cycle counter/timer stop strobe |

## Verification
The hardest situation to reach is a latch bit that was hit by set or clear writes while its pin was handed to another source. The pins show nothing of this until the select is cleared again. The stimulus fills the port with an all-ones set while four pins are diverted, then drops the selects and checks that those four pins are still high. Long mixed runs also interleave select, set, clear and command writes with toggling status flags, so that stale latch contents surface whenever a select falls.

// File: rtl/gpo_pkg.sv
`timescale 1ns/1ps
package gpo_pkg;

  localparam int GPO_ADDR_W = 4;
  localparam int GPO_PINS   = 8;

  // Pin positions of the diverted functions
  localparam int PIN_RTS = 0;
  localparam int PIN_RXB = 5;
  localparam int PIN_TXA = 6;
  localparam int PIN_TXB = 7;

  // Number of function-select bits kept
  localparam int SEL_BITS = 4;

  // Command nibbles for the request-to-send state
  localparam logic [3:0] CMD_RTS_ON  = 4'h8;
  localparam logic [3:0] CMD_RTS_OFF = 4'h9;

  typedef struct packed {
    logic cmd;
    logic cfg;
    logic set;
    logic clr;
  } wr_sel_t;

endpackage

// File: rtl/gpo_bus_decode.sv
`timescale 1ns/1ps
module gpo_bus_decode
  import gpo_pkg::*;
#(
  parameter int                ADDR_W   = GPO_ADDR_W,
  parameter logic [ADDR_W-1:0] ADR_CMD  = 'h2,
  parameter logic [ADDR_W-1:0] ADR_CFG  = 'hD,
  parameter logic [ADDR_W-1:0] ADR_SET  = 'hE,
  parameter logic [ADDR_W-1:0] ADR_CLR  = 'hF,
  parameter logic [ADDR_W-1:0] ADR_GO   = 'hE,
  parameter logic [ADDR_W-1:0] ADR_HALT = 'hF
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr,
  input  logic              rd,
  output wr_sel_t           wsel,
  output logic              go_pulse,
  output logic              halt_pulse
);

  logic rd_go, rd_halt;

  always_comb begin
    wsel.cmd = wr && (addr == ADR_CMD);
    wsel.cfg = wr && (addr == ADR_CFG);
    wsel.set = wr && (addr == ADR_SET);
    wsel.clr = wr && (addr == ADR_CLR);
    rd_go    = rd && (addr == ADR_GO);
    rd_halt  = rd && (addr == ADR_HALT);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      go_pulse   <= 1'b0;
      halt_pulse <= 1'b0;
    end else begin
      go_pulse   <= rd_go;
      halt_pulse <= rd_halt;
    end
  end

  // R7: a start read yields a strobe on the next cycle
  a_r7_go_follows_read: assert property (@(posedge clk) disable iff (rst)
    (rd && addr == ADR_GO) |=> go_pulse);
  // R7: a stop read yields a strobe on the next cycle
  a_r7_halt_follows_read: assert property (@(posedge clk) disable iff (rst)
    (rd && addr == ADR_HALT) |=> halt_pulse);
  // R7: a start strobe requires a read strobe in the previous cycle
  a_r7_go_needs_read: assert property (@(posedge clk) disable iff (rst)
    go_pulse |-> $past(rd));

endmodule

// File: rtl/gpo_ctrl_regs.sv
`timescale 1ns/1ps
module gpo_ctrl_regs
  import gpo_pkg::*;
#(
  parameter int N_PINS = GPO_PINS
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                cfg_we,
  input  logic [SEL_BITS-1:0] cfg_bits,
  input  logic                cmd_we,
  input  logic [3:0]          cmd_nib,
  output logic [N_PINS-1:0]   sel_mask,
  output logic                rts_q
);

  logic [SEL_BITS-1:0] cfg_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q <= '0;
    end else if (cfg_we) begin
      cfg_q <= cfg_bits;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rts_q <= 1'b0;
    end else if (cmd_we) begin
      if (cmd_nib == CMD_RTS_ON) begin
        rts_q <= 1'b1;
      end else if (cmd_nib == CMD_RTS_OFF) begin
        rts_q <= 1'b0;
      end
    end
  end

  // Spread the select bits over the pin positions
  always_comb begin
    sel_mask          = '0;
    sel_mask[PIN_RTS] = cfg_q[0];
    sel_mask[PIN_RXB] = cfg_q[1];
    sel_mask[PIN_TXA] = cfg_q[2];
    sel_mask[PIN_TXB] = cfg_q[3];
  end

  // R6: the assert command sets the state
  a_r6_rts_on: assert property (@(posedge clk) disable iff (rst)
    (cmd_we && cmd_nib == CMD_RTS_ON) |=> rts_q);
  // R6: the negate command clears the state
  a_r6_rts_off: assert property (@(posedge clk) disable iff (rst)
    (cmd_we && cmd_nib == CMD_RTS_OFF) |=> !rts_q);
  // R6: without a command write the state holds
  a_r6_rts_hold: assert property (@(posedge clk) disable iff (rst)
    !cmd_we |=> $stable(rts_q));
  // R4: the selects change only on a configuration write
  a_r4_sel_hold: assert property (@(posedge clk) disable iff (rst)
    !cfg_we |=> $stable(sel_mask));

endmodule

// File: rtl/gpo_latch.sv
`timescale 1ns/1ps
module gpo_latch
  import gpo_pkg::*;
#(
  parameter int N_PINS = GPO_PINS
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              set_en,
  input  logic              clr_en,
  input  logic [N_PINS-1:0] data,
  input  logic [N_PINS-1:0] protect,
  output logic [N_PINS-1:0] latch_q
);

  // latch_q bit = 1 means the pin is asserted (driven low)
  for (genvar i = 0; i < N_PINS; i++) begin : g_bit
    logic q;
    logic hit;

    assign hit = data[i] && !protect[i];

    always_ff @(posedge clk) begin
      if (rst) begin
        q <= 1'b0;
      end else if (set_en && hit) begin
        q <= 1'b1;
      end else if (clr_en && hit) begin
        q <= 1'b0;
      end
    end

    assign latch_q[i] = q;

    // R2: set write on an unprotected bit asserts it
    a_r2_set_takes: assert property (@(posedge clk) disable iff (rst)
      (set_en && data[i] && !protect[i]) |=> latch_q[i]);
    // R3: clear write on an unprotected bit negates it
    a_r3_clr_takes: assert property (@(posedge clk) disable iff (rst)
      (clr_en && data[i] && !protect[i]) |=> !latch_q[i]);
    // R5: a protected bit keeps its value through any write
    a_r5_protected_kept: assert property (@(posedge clk) disable iff (rst)
      protect[i] |=> $stable(latch_q[i]));
  end

  // R3: with neither write the latch holds
  a_r3_idle_hold: assert property (@(posedge clk) disable iff (rst)
    !(set_en || clr_en) |=> $stable(latch_q));

endmodule

// File: rtl/gpo_pin_mux.sv
`timescale 1ns/1ps
module gpo_pin_mux
  import gpo_pkg::*;
#(
  parameter int N_PINS = GPO_PINS
) (
  input  logic [N_PINS-1:0] latch_q,
  input  logic [N_PINS-1:0] alt_q,
  input  logic [N_PINS-1:0] sel,
  output logic [N_PINS-1:0] pin_n
);

  for (genvar i = 0; i < N_PINS; i++) begin : g_pin
    logic asserted;
    assign asserted = sel[i] ? alt_q[i] : latch_q[i];
    assign pin_n[i] = ~asserted;
  end

endmodule

// File: rtl/gpo_setclr_port.sv
`timescale 1ns/1ps
module gpo_setclr_port
  import gpo_pkg::*;
#(
  parameter int                ADDR_W   = GPO_ADDR_W,
  parameter int                N_PINS   = GPO_PINS,
  parameter logic [ADDR_W-1:0] ADR_CMD  = 'h2,
  parameter logic [ADDR_W-1:0] ADR_CFG  = 'hD,
  parameter logic [ADDR_W-1:0] ADR_SET  = 'hE,
  parameter logic [ADDR_W-1:0] ADR_CLR  = 'hF,
  parameter logic [ADDR_W-1:0] ADR_GO   = 'hE,
  parameter logic [ADDR_W-1:0] ADR_HALT = 'hF
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [N_PINS-1:0] bus_wdata,
  input  logic              rxb_ready,
  input  logic              txa_ready,
  input  logic              txb_ready,
  output logic [N_PINS-1:0] port_n,
  output logic              ct_start,
  output logic              ct_stop
);

  localparam int NIB_HI = N_PINS - 1;

  wr_sel_t             wsel;
  logic [N_PINS-1:0]   sel_mask;
  logic [N_PINS-1:0]   latch_q;
  logic [N_PINS-1:0]   alt_vec;
  logic [SEL_BITS-1:0] cfg_bits;
  logic                rts_q;

  gpo_bus_decode #(
    .ADDR_W  (ADDR_W),
    .ADR_CMD (ADR_CMD),
    .ADR_CFG (ADR_CFG),
    .ADR_SET (ADR_SET),
    .ADR_CLR (ADR_CLR),
    .ADR_GO  (ADR_GO),
    .ADR_HALT(ADR_HALT)
  ) i_decode (
    .clk       (clk),
    .rst       (rst),
    .addr      (bus_addr),
    .wr        (bus_wr),
    .rd        (bus_rd),
    .wsel      (wsel),
    .go_pulse  (ct_start),
    .halt_pulse(ct_stop)
  );

  assign cfg_bits = {bus_wdata[PIN_TXB], bus_wdata[PIN_TXA],
                     bus_wdata[PIN_RXB], bus_wdata[PIN_RTS]};

  gpo_ctrl_regs #(
    .N_PINS(N_PINS)
  ) i_ctrl (
    .clk     (clk),
    .rst     (rst),
    .cfg_we  (wsel.cfg),
    .cfg_bits(cfg_bits),
    .cmd_we  (wsel.cmd),
    .cmd_nib (bus_wdata[NIB_HI -: 4]),
    .sel_mask(sel_mask),
    .rts_q   (rts_q)
  );

  gpo_latch #(
    .N_PINS(N_PINS)
  ) i_latch (
    .clk    (clk),
    .rst    (rst),
    .set_en (wsel.set),
    .clr_en (wsel.clr),
    .data   (bus_wdata),
    .protect(sel_mask),
    .latch_q(latch_q)
  );

  always_comb begin
    alt_vec          = '0;
    alt_vec[PIN_RTS] = rts_q;
    alt_vec[PIN_RXB] = rxb_ready;
    alt_vec[PIN_TXA] = txa_ready;
    alt_vec[PIN_TXB] = txb_ready;
  end

  gpo_pin_mux #(
    .N_PINS(N_PINS)
  ) i_mux (
    .latch_q(latch_q),
    .alt_q  (alt_vec),
    .sel    (sel_mask),
    .pin_n  (port_n)
  );

  // R7: the two strobes never fire together under one access per clock
  a_r7_strobes_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(ct_start && ct_stop));
  // R3: a read leaves every latch-driven pin where it was
  a_r3_read_no_pin_change: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && !bus_wr) |=> ($stable(latch_q)));

endmodule

// File: tb/test_gpo_setclr_port.sv
`timescale 1ns/1ps
module test_gpo_setclr_port;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [3:0] bus_addr = '0;
  logic       bus_wr = 1'b0;
  logic       bus_rd = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic       rxb_ready = 1'b0;
  logic       txa_ready = 1'b0;
  logic       txb_ready = 1'b0;
  logic [7:0] port_n;
  logic       ct_start, ct_stop;

  always #10 clk = ~clk;

  gpo_setclr_port i_gpo_setclr_port (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_wdata(bus_wdata), .rxb_ready(rxb_ready),
    .txa_ready(txa_ready), .txb_ready(txb_ready), .port_n(port_n),
    .ct_start(ct_start), .ct_stop(ct_stop)
  );

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  // Behavioural reference: m_on bit = 1 means the pin is pulled low
  logic [7:0] m_on;
  bit m_sel0, m_sel5, m_sel6, m_sel7, m_rts, m_go, m_halt;

  function automatic logic [7:0] m_div();
    logic [7:0] d = 8'h00;
    d[0] = m_sel0; d[5] = m_sel5; d[6] = m_sel6; d[7] = m_sel7;
    return d;
  endfunction

  function automatic logic [7:0] m_pins();
    logic [7:0] p;
    for (int i = 0; i < 8; i++) p[i] = !m_on[i];
    if (m_sel0) p[0] = !m_rts;
    if (m_sel5) p[5] = !rxb_ready;
    if (m_sel6) p[6] = !txa_ready;
    if (m_sel7) p[7] = !txb_ready;
    return p;
  endfunction

  task automatic model_edge();
    if (rst) begin
      m_on = 8'h00; m_sel0 = 0; m_sel5 = 0; m_sel6 = 0; m_sel7 = 0;
      m_rts = 0; m_go = 0; m_halt = 0;
    end else begin
      m_go   = bus_rd && bus_addr == 4'hE;
      m_halt = bus_rd && bus_addr == 4'hF;
      if (bus_wr) begin
        case (bus_addr)
          4'hD: begin
            m_sel0 = bus_wdata[0]; m_sel5 = bus_wdata[5];
            m_sel6 = bus_wdata[6]; m_sel7 = bus_wdata[7];
          end
          4'hE: m_on = m_on | (bus_wdata & ~m_div());
          4'hF: m_on = m_on & ~(bus_wdata & ~m_div());
          4'h2: begin
            if (bus_wdata[7:4] == 4'h8) m_rts = 1;
            else if (bus_wdata[7:4] == 4'h9) m_rts = 0;
          end
          default: ;
        endcase
      end
    end
  endtask

  task automatic check(input string tag);
    logic [7:0] ep;
    ep = m_pins();
    n_chk++;
    if (port_n !== ep || ct_start !== m_go || ct_stop !== m_halt) begin
      n_fail++;
      $display("FAIL %s: port_n=%h start=%b stop=%b, expected port_n=%h start=%b stop=%b",
               tag, port_n, ct_start, ct_stop, ep, m_go, m_halt);
    end
  endtask

  task automatic cyc(input logic [3:0] a, input bit w, input bit r,
                     input logic [7:0] d, input string tag);
    bus_addr = a; bus_wr = w; bus_rd = r; bus_wdata = d;
    @(posedge clk);
    model_edge();
    @(negedge clk);
    check(tag);
  endtask

  task automatic idle(input string tag);
    cyc(4'h0, 0, 0, 8'h00, tag);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: run did not finish, expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    logic [3:0] addr_pool [5];
    addr_pool[0] = 4'h2; addr_pool[1] = 4'hD; addr_pool[2] = 4'hE;
    addr_pool[3] = 4'hF; addr_pool[4] = 4'h3;

    // R1: reset state
    rst = 1;
    repeat (3) idle("R1");
    rst = 0;
    idle("R1");

    // R2: set pattern, then another overlapping pattern
    cyc(4'hE, 1, 0, 8'hA5, "R2");
    cyc(4'hE, 1, 0, 8'h0C, "R2");
    // R3: holding through idle, reads and unrelated writes
    idle("R3");
    cyc(4'h3, 1, 0, 8'hFF, "R3");
    cyc(4'h3, 0, 1, 8'h00, "R3");
    cyc(4'hF, 1, 0, 8'h01, "R3");
    cyc(4'hF, 1, 0, 8'hFF, "R3");

    // R4: divert pins 0,5,6,7 and toggle status flags mid-cycle
    cyc(4'hD, 1, 0, 8'hE1, "R4");
    rxb_ready = 1; #1 check("R4");
    txa_ready = 1; #1 check("R4");
    txb_ready = 1; rxb_ready = 0; #1 check("R4");
    idle("R4");

    // R5: writes to diverted pins leave their latch bits alone
    rxb_ready = 0; txa_ready = 0; txb_ready = 0;
    cyc(4'hE, 1, 0, 8'hFF, "R5");
    cyc(4'hD, 1, 0, 8'h00, "R5");
    cyc(4'hE, 1, 0, 8'hFF, "R5");
    cyc(4'hD, 1, 0, 8'hE1, "R5");
    cyc(4'hF, 1, 0, 8'hFF, "R5");
    cyc(4'hD, 1, 0, 8'h00, "R5");
    cyc(4'hF, 1, 0, 8'hFF, "R5");

    // R6: request-to-send commands on pin 0
    cyc(4'hD, 1, 0, 8'h01, "R6");
    cyc(4'h2, 1, 0, 8'h80, "R6");
    cyc(4'h2, 1, 0, 8'h35, "R6");
    cyc(4'h2, 1, 0, 8'h9F, "R6");
    cyc(4'h2, 1, 0, 8'h8A, "R6");
    cyc(4'hD, 1, 0, 8'h00, "R6");
    cyc(4'h2, 1, 0, 8'h90, "R6");

    // R7: strobes from reads only
    cyc(4'hE, 0, 1, 8'h00, "R7");
    idle("R7");
    cyc(4'hF, 0, 1, 8'h00, "R7");
    cyc(4'hE, 0, 1, 8'h00, "R7");
    cyc(4'h3, 0, 1, 8'h00, "R7");
    cyc(4'hE, 1, 0, 8'h00, "R7");
    idle("R7");

    // Mixed traffic
    for (int k = 0; k < 4000; k++) begin
      logic [3:0] a;
      int op;
      string tag;
      a  = addr_pool[$urandom_range(0, 4)];
      op = $urandom_range(0, 2);
      rxb_ready = 1'($urandom); txa_ready = 1'($urandom); txb_ready = 1'($urandom);
      if (op == 2) tag = "R7";
      else if (op == 0) tag = "R3";
      else if (a == 4'hD) tag = "R4";
      else if (a == 4'hE) tag = "R2";
      else if (a == 4'hF) tag = "R5";
      else if (a == 4'h2) tag = "R6";
      else tag = "R3";
      cyc(a, op == 1, op == 2, 8'($urandom), tag);
    end

    // R1: reset again from a busy state
    rst = 1;
    idle("R1");
    rst = 0;
    idle("R1");

    done = 1;
    summary();
    $finish;
  end

endmodule